// File: doc/BRIEF.md
# 100BASE-X Transmit Code-Group Framer

This block sits between the transmit side of a MAC nibble interface and the physical coding layer of a 100 Mb/s link. On every nibble clock it emits one 5-bit code-group. While the MAC is silent it sends the Idle code-group without a break. When the MAC raises its enable, the first two nibbles of the preamble are dropped and the start delimiter pair /J/ then /K/ goes out in their place. Every later nibble is mapped through the 4B/5B data table. When the enable falls, the end delimiter pair /T/ then /R/ follows, and the stream goes back to Idle.

A nibble that the MAC marks as errored while the frame is in progress is replaced by the Halt code-group. The output carries a valid flag and a frame-active flag for a downstream scrambler or carrier-sense stage. Scrambling, line coding, serialization and the receive path belong to other blocks.

Top module: `tx_pcs_framer`

## Requirements
- R1: A synchronous active-high reset makes cg_code Idle (11111), drives cg_valid and cg_active low, and abandons any frame in progress.
- R2: While no frame is in progress and tx_en is low, cg_code is Idle on every cycle.
- R3: The first two nibbles of a frame are not encoded. They are replaced by /J/ (11000) and then /K/ (10001) on consecutive cycles, whatever their data or tx_er value.
- R4: Each later nibble of the frame is sent in order as its 4B/5B code: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R5: The first cycle in which tx_en is low after a frame yields /T/ (01101). The next cycle yields /R/ (00111), and the output then returns to Idle.
- R6: A nibble presented at the inputs before clock edge k appears on cg_code just after edge k+1, which is a fixed latency of two edges.
- R7: A frame nibble with tx_er high that falls after the /J/K/ slots is sent as Halt (00100).
- R8: A frame whose tx_en lasts only one nibble still produces the full sequence /J/, /K/, /T/, /R/.
- R9: cg_valid is high on every cycle after the first edge out of reset. cg_active is high exactly when cg_code is not Idle.
- R10: tx_er and the data input have no effect while no frame is in progress and tx_en is low. The output stays Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| mii_txd | input | 4 | Transmit data nibble |
| mii_tx_en | input | 1 | Frame enable from the MAC |
| mii_tx_er | input | 1 | Transmit error mark for the current nibble |
| cg_code | output | 5 | Code-group for the physical medium |
| cg_valid | output | 1 | Code-group is meaningful (high after reset ends) |
| cg_active | output | 1 | Code-group belongs to a frame (delimiters, data or Halt) |

## Verification
The hardest case to reach is a frame that ends while the start delimiter is still going out. In that case the enable has already fallen by the time /K/ is emitted, and the block must still close with /T/R/. The stimulus table drives a one-nibble frame to reach it. It also places an error mark on the nibble that /K/ replaces, and an error mark on an idle line, so that both can be seen to vanish. A directed frame then walks all sixteen nibble values, and a reset is applied in the middle of a frame.

// File: rtl/tx_pcs_pkg.sv
package tx_pcs_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_K,
    ST_DATA,
    ST_SEND_T,
    ST_SEND_R
  } frm_state_t;

  typedef struct packed {
    logic             en;
    logic             er;
    logic [NIB_W-1:0] d;
  } mii_beat_t;
endpackage

// File: rtl/tx_mii_capture.sv
module tx_mii_capture
  import tx_pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  output mii_beat_t        beat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      beat <= '0;
    end else begin
      beat.en <= tx_en;
      beat.er <= tx_er;
      beat.d  <= txd;
    end
  end
endmodule

// File: rtl/tx_nibble_enc.sv
module tx_nibble_enc
  import tx_pcs_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [CG_W-1:0]  code
);
  always_comb begin
    case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_pcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  mii_beat_t       beat,
  input  logic [CG_W-1:0] data_code,
  output logic [CG_W-1:0] cg_code,
  output logic            cg_valid,
  output logic            cg_active
);
  frm_state_t      st, nxt_st;
  logic [CG_W-1:0] nxt_cg;

  always_comb begin
    nxt_st = st;
    nxt_cg = CG_IDLE;
    case (st)
      ST_IDLE: begin
        if (beat.en) begin
          nxt_cg = CG_J;
          nxt_st = ST_SEND_K;
        end
      end
      ST_SEND_K: begin
        nxt_cg = CG_K;
        nxt_st = beat.en ? ST_DATA : ST_SEND_T;
      end
      ST_DATA: begin
        if (beat.en) begin
          nxt_cg = beat.er ? CG_HALT : data_code;
        end else begin
          nxt_cg = CG_T;
          nxt_st = ST_SEND_R;
        end
      end
      ST_SEND_T: begin
        nxt_cg = CG_T;
        nxt_st = ST_SEND_R;
      end
      ST_SEND_R: begin
        nxt_cg = CG_R;
        nxt_st = ST_IDLE;
      end
      default: begin
        nxt_st = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cg_code   <= CG_IDLE;
      cg_valid  <= 1'b0;
      cg_active <= 1'b0;
    end else begin
      st        <= nxt_st;
      cg_code   <= nxt_cg;
      cg_valid  <= 1'b1;
      cg_active <= (nxt_cg != CG_IDLE);
    end
  end

  p_jk_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (cg_code == CG_J) |=> (cg_code == CG_K));

  p_t_then_r_r5: assert property (@(posedge clk) disable iff (rst)
    (cg_code == CG_T) |=> (cg_code == CG_R));

  p_r_then_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (cg_code == CG_R) |=> (cg_code == CG_IDLE || cg_code == CG_J));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !beat.en) |=> (cg_code == CG_IDLE));

  p_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && beat.en && beat.er) |=> (cg_code == CG_HALT));

  p_short_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND_K && !beat.en) |=> ##1 (cg_code == CG_T));

  p_valid_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cg_valid);
endmodule

// File: rtl/tx_pcs_framer.sv
module tx_pcs_framer
  import tx_pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] mii_txd,
  input  logic             mii_tx_en,
  input  logic             mii_tx_er,
  output logic [CG_W-1:0]  cg_code,
  output logic             cg_valid,
  output logic             cg_active
);
  mii_beat_t       beat;
  logic [CG_W-1:0] data_code;

  tx_mii_capture u_cap (
    .clk   (clk),
    .rst   (rst),
    .txd   (mii_txd),
    .tx_en (mii_tx_en),
    .tx_er (mii_tx_er),
    .beat  (beat)
  );

  tx_nibble_enc u_enc (
    .nib  (beat.d),
    .code (data_code)
  );

  tx_frame_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .beat      (beat),
    .data_code (data_code),
    .cg_code   (cg_code),
    .cg_valid  (cg_valid),
    .cg_active (cg_active)
  );
endmodule

// File: tb/tx_pcs_framer_tb.sv
module tx_pcs_framer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] txd = 4'h0;
  logic       en  = 1'b0;
  logic       er  = 1'b0;
  logic [4:0] code;
  logic       valid, active;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [4:0] I = 5'b11111, J = 5'b11000, K = 5'b10001;
  localparam logic [4:0] T = 5'b01101, R = 5'b00111, H = 5'b00100;

  // {en, er, txd, expected code at this sample}; expected follows input two rows back
  localparam int NV = 27;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b0,4'h0,I},       // R2
    {1'b1,1'b0,4'h5,I},
    {1'b1,1'b0,4'h5,I},
    {1'b1,1'b0,4'h5,J},       // R3 R6
    {1'b1,1'b0,4'h5,K},
    {1'b1,1'b0,4'hD,5'b01011},// R4
    {1'b1,1'b0,4'h3,5'b01011},
    {1'b1,1'b0,4'hA,5'b11011},
    {1'b0,1'b0,4'h0,5'b10101},
    {1'b0,1'b0,4'h0,5'b10110},
    {1'b0,1'b0,4'h0,T},       // R5
    {1'b1,1'b0,4'h5,R},
    {1'b0,1'b0,4'h0,I},
    {1'b0,1'b0,4'h0,J},       // R8
    {1'b0,1'b0,4'h0,K},
    {1'b0,1'b1,4'h9,T},       // R10 stimulus
    {1'b0,1'b0,4'h0,R},
    {1'b1,1'b0,4'h5,I},       // R10 result
    {1'b1,1'b1,4'h5,I},
    {1'b1,1'b0,4'h0,J},
    {1'b1,1'b1,4'h7,K},       // R3 error mark replaced
    {1'b1,1'b0,4'hF,5'b11110},
    {1'b0,1'b0,4'h0,H},       // R7
    {1'b0,1'b0,4'h0,5'b11101},
    {1'b0,1'b0,4'h0,T},
    {1'b0,1'b0,4'h0,R},
    {1'b0,1'b0,4'h0,I}
  };

  tx_pcs_framer u_dut (
    .clk       (clk),
    .rst       (rst),
    .mii_txd   (txd),
    .mii_tx_en (en),
    .mii_tx_er (er),
    .cg_code   (code),
    .cg_valid  (valid),
    .cg_active (active)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req, input logic [4:0] exp);
    check(req, {code, valid, active}, {exp, 1'b1, exp != I});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {code, valid, active}, {I, 1'b0, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    check("R9 valid after reset", {code, valid, active}, {I, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_out($sformatf("R2-R10 vector %0d", i), VEC[i][4:0]);
      en  = VEC[i][10];
      er  = VEC[i][9];
      txd = VEC[i][8:5];
    end

    // R4: every nibble value inside one frame
    for (int k = 0; k < 22; k++) begin
      logic [4:0] exp;
      @(negedge clk);
      if (k >= 2) begin
        if (k == 2) exp = J;
        else if (k == 3) exp = K;
        else if (k < 20) exp = enc(4'(k - 4));
        else if (k == 20) exp = T;
        else exp = R;
        check_out("R4 R6 full table", exp);
      end
      en  = (k < 18);
      er  = 1'b0;
      txd = (k < 2) ? 4'h5 : 4'(k - 2);
    end
    @(negedge clk);
    check_out("R5 back to idle", I);

    // R1: reset in the middle of a frame
    en = 1'b1; txd = 4'h5;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-frame reset", {code, valid, active}, {I, 1'b0, 1'b0});
    en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R1 R2 idle after reset", I);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule